// File: doc/BRIEF.md
# Debug Match Privilege Qualifier

This combinational block decides whether a raw address-match event from the debug comparators should become a real debug event. It looks at the current processor state (problem state, hypervisor state and data relocation) and at the control words that software programmed for one instruction breakpoint and several data watchpoints. It then reports which events survive. Address comparison happens upstream and exception delivery happens downstream, so neither is part of this block.

For the instruction breakpoint, a 2-bit privilege-class field in its control word selects the one privilege level in which the breakpoint may fire. Each data watchpoint has its own control word. That word holds a separate enable for problem state, hypervisor state and supervisor access. It also holds a translation-mode selector and a flag that makes translation mode irrelevant. A small selector turns the qualified events into an exception class and a status word for the exception path. The instruction breakpoint is preferred when both kinds fire in the same cycle.

Control words use big-endian bit numbering. Bit 0 is the most significant bit and bit 63 is the least significant bit of a 64-bit word.

Top module: `dbg_qual`

## Requirements
- R1: When the breakpoint class field (control bits 62:63, the value read with bit 62 as its MSB) equals 1, `bp_hit_o` is high only if `bp_match_i` is high and problem state is set.
- R2: When the class field equals 2, `bp_hit_o` is high only if `bp_match_i` is high, problem state is clear and hypervisor state is clear.
- R3: When the class field equals 3, `bp_hit_o` is high only if `bp_match_i` is high, problem state is clear and hypervisor state is set.
- R4: Class field value 0 never produces a breakpoint hit. No qualified output of either kind is high while its raw match input is low.
- R5: A watchpoint control word carries a problem enable at bit 63, a supervisor enable at bit 62 and a hypervisor enable at bit 61. A watchpoint is suppressed in three cases: problem state is set and its problem enable is clear; hypervisor state is set and its hypervisor enable is clear; its supervisor enable is clear, in any state.
- R6: Bit 60 of the watchpoint word is the translation-ignore flag and bit 59 is the translation selector. With the flag clear, a watchpoint fires only if data relocation equals the selector. With the flag set, data relocation has no effect.
- R7: Each watchpoint is qualified only from its own control word and its own raw match, and drives its own bit of `wp_hit_o`. Activity on one watchpoint never raises another watchpoint's output.
- R8: `excp_kind_o` is 0 with an all-zero status when nothing is qualified. It is 1 (storage) with only big-endian bit 41 of the status set when only watchpoints are qualified. It is 2 (trace) with only big-endian bits 33 and 43 set whenever the breakpoint is qualified, including when watchpoints are qualified in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| state_pr_i | input | 1 | Processor is in problem (user) state |
| state_hv_i | input | 1 | Processor is in hypervisor state |
| state_dr_i | input | 1 | Data relocation (translation) is on |
| bp_ctl_i | input | CTL_W | Instruction breakpoint control word |
| bp_match_i | input | 1 | Raw instruction address match |
| wp_ctl_i | input | NUM_WP x CTL_W | Watchpoint control words, one per watchpoint |
| wp_match_i | input | NUM_WP | Raw data address match, one per watchpoint |
| bp_hit_o | output | 1 | Qualified instruction breakpoint |
| wp_hit_o | output | NUM_WP | Qualified data watchpoints |
| excp_kind_o | output | 2 | Exception class: 0 none, 1 storage, 2 trace |
| excp_status_o | output | STAT_W | Status word for the exception path |

## Verification
The immediate assertions assume that the state bits, raw matches and control words are settled two-valued levels. They also assume the block is judged after its combinational paths have resolved, so the assertions treat each input set as stable.

The stimulus keeps to these assumptions. It changes inputs only just after a rising clock edge and compares the outputs at the following falling edge. Every input is driven to a defined 0 or 1. Control-word bits outside the decoded fields are held at zero.

The exhaustive sweeps cover every legal combination of state bits, class field, enable bits and match. Because of that, each suppression rule is reached from every privilege state rather than from a single chosen one.

// File: rtl/dbg_qual_pkg.sv
package dbg_qual_pkg;

  localparam int CTL_W_DEF  = 64;
  localparam int STAT_W_DEF = 64;
  localparam int NUM_WP_DEF = 2;

  // big-endian bit numbers within a control or status word
  localparam int BP_CLS_HI_BE = 62;
  localparam int BP_CLS_LO_BE = 63;
  localparam int WP_XSEL_BE   = 59;
  localparam int WP_XIGN_BE   = 60;
  localparam int WP_HVEN_BE   = 61;
  localparam int WP_SVEN_BE   = 62;
  localparam int WP_PREN_BE   = 63;
  localparam int ST_STG_BE    = 41;
  localparam int ST_TRC_A_BE  = 33;
  localparam int ST_TRC_B_BE  = 43;

  typedef enum logic [1:0] {
    BPC_NEVER   = 2'd0,
    BPC_PROBLEM = 2'd1,
    BPC_SUPER   = 2'd2,
    BPC_HYPER   = 2'd3
  } bp_class_e;

  typedef enum logic [1:0] {
    EXC_NONE    = 2'd0,
    EXC_STORAGE = 2'd1,
    EXC_TRACE   = 2'd2
  } exc_kind_e;

endpackage

// File: rtl/priv_decode.sv
module priv_decode
  import dbg_qual_pkg::*;
(
  input  logic      pr_i,
  input  logic      hv_i,
  output bp_class_e cls_o
);

  always_comb begin
    if (pr_i)      cls_o = BPC_PROBLEM;
    else if (hv_i) cls_o = BPC_HYPER;
    else           cls_o = BPC_SUPER;
  end

endmodule

// File: rtl/bp_qual.sv
module bp_qual
  import dbg_qual_pkg::*;
#(
  parameter int CTL_W = CTL_W_DEF
) (
  input  logic [CTL_W-1:0] ctl_i,
  input  logic             match_i,
  input  bp_class_e        cls_i,
  output logic             hit_o
);

  localparam int HI = CTL_W - 1 - BP_CLS_HI_BE;
  localparam int LO = CTL_W - 1 - BP_CLS_LO_BE;

  bp_class_e field;
  logic      unused_ctl;

  assign field      = bp_class_e'({ctl_i[HI], ctl_i[LO]});
  assign unused_ctl = ^ctl_i;
  assign hit_o      = match_i && (field != BPC_NEVER) && (field == cls_i);

  always_comb begin
    a_r4_bp_gate: assert (match_i || !hit_o)
      else $error("R4 breakpoint hit without raw match");
    a_r4_never: assert ((field != BPC_NEVER) || !hit_o)
      else $error("R4 class 0 produced a hit");
  end

endmodule

// File: rtl/wp_qual.sv
module wp_qual
  import dbg_qual_pkg::*;
#(
  parameter int CTL_W = CTL_W_DEF
) (
  input  logic [CTL_W-1:0] ctl_i,
  input  logic             match_i,
  input  logic             pr_i,
  input  logic             hv_i,
  input  logic             dr_i,
  output logic             hit_o
);

  localparam int XSEL = CTL_W - 1 - WP_XSEL_BE;
  localparam int XIGN = CTL_W - 1 - WP_XIGN_BE;
  localparam int HVEN = CTL_W - 1 - WP_HVEN_BE;
  localparam int SVEN = CTL_W - 1 - WP_SVEN_BE;
  localparam int PREN = CTL_W - 1 - WP_PREN_BE;

  logic priv_ok;
  logic xlat_ok;
  logic unused_ctl;

  assign unused_ctl = ^ctl_i;

  always_comb begin
    if (pr_i && !ctl_i[PREN])      priv_ok = 1'b0;
    else if (hv_i && !ctl_i[HVEN]) priv_ok = 1'b0;
    else                           priv_ok = ctl_i[SVEN];
  end

  assign xlat_ok = ctl_i[XIGN] || (dr_i == ctl_i[XSEL]);
  assign hit_o   = match_i && priv_ok && xlat_ok;

  always_comb begin
    a_r4_wp_gate: assert (match_i || !hit_o)
      else $error("R4 watchpoint hit without raw match");
    a_r5_pr_off: assert (!(pr_i && !ctl_i[PREN]) || !hit_o)
      else $error("R5 problem-state watchpoint not suppressed");
    a_r5_hv_off: assert (!(hv_i && !ctl_i[HVEN]) || !hit_o)
      else $error("R5 hypervisor watchpoint not suppressed");
    a_r5_sv_off: assert (ctl_i[SVEN] || !hit_o)
      else $error("R5 watchpoint fired with supervisor enable clear");
    a_r6_xlat: assert (ctl_i[XIGN] || (dr_i == ctl_i[XSEL]) || !hit_o)
      else $error("R6 translation mode mismatch fired");
  end

endmodule

// File: rtl/status_sel.sv
module status_sel
  import dbg_qual_pkg::*;
#(
  parameter int NUM_WP = NUM_WP_DEF,
  parameter int STAT_W = STAT_W_DEF
) (
  input  logic              bp_hit_i,
  input  logic [NUM_WP-1:0] wp_hit_i,
  output exc_kind_e         kind_o,
  output logic [STAT_W-1:0] status_o
);

  localparam logic [STAT_W-1:0] ONE     = {{(STAT_W-1){1'b0}}, 1'b1};
  localparam logic [STAT_W-1:0] STG_VAL = ONE << (STAT_W - 1 - ST_STG_BE);
  localparam logic [STAT_W-1:0] TRC_VAL = (ONE << (STAT_W - 1 - ST_TRC_A_BE)) |
                                          (ONE << (STAT_W - 1 - ST_TRC_B_BE));

  // breakpoint precedes the data access it would have guarded
  always_comb begin
    if (bp_hit_i) begin
      kind_o   = EXC_TRACE;
      status_o = TRC_VAL;
    end else if (|wp_hit_i) begin
      kind_o   = EXC_STORAGE;
      status_o = STG_VAL;
    end else begin
      kind_o   = EXC_NONE;
      status_o = '0;
    end
  end

endmodule

// File: rtl/dbg_qual.sv
module dbg_qual
  import dbg_qual_pkg::*;
#(
  parameter int CTL_W  = CTL_W_DEF,
  parameter int STAT_W = STAT_W_DEF,
  parameter int NUM_WP = NUM_WP_DEF
) (
  input  logic                        state_pr_i,
  input  logic                        state_hv_i,
  input  logic                        state_dr_i,
  input  logic [CTL_W-1:0]            bp_ctl_i,
  input  logic                        bp_match_i,
  input  logic [NUM_WP-1:0][CTL_W-1:0] wp_ctl_i,
  input  logic [NUM_WP-1:0]           wp_match_i,
  output logic                        bp_hit_o,
  output logic [NUM_WP-1:0]           wp_hit_o,
  output logic [1:0]                  excp_kind_o,
  output logic [STAT_W-1:0]           excp_status_o
);

  bp_class_e cur_cls;
  exc_kind_e kind;

  priv_decode u_priv (
    .pr_i  (state_pr_i),
    .hv_i  (state_hv_i),
    .cls_o (cur_cls)
  );

  bp_qual #(.CTL_W(CTL_W)) u_bp (
    .ctl_i   (bp_ctl_i),
    .match_i (bp_match_i),
    .cls_i   (cur_cls),
    .hit_o   (bp_hit_o)
  );

  for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
    wp_qual #(.CTL_W(CTL_W)) u_wp (
      .ctl_i   (wp_ctl_i[g]),
      .match_i (wp_match_i[g]),
      .pr_i    (state_pr_i),
      .hv_i    (state_hv_i),
      .dr_i    (state_dr_i),
      .hit_o   (wp_hit_o[g])
    );
  end

  status_sel #(.NUM_WP(NUM_WP), .STAT_W(STAT_W)) u_stat (
    .bp_hit_i (bp_hit_o),
    .wp_hit_i (wp_hit_o),
    .kind_o   (kind),
    .status_o (excp_status_o)
  );

  assign excp_kind_o = kind;

  always_comb begin
    a_r8_trace: assert (!bp_hit_o || (kind == EXC_TRACE))
      else $error("R8 breakpoint hit not reported as trace");
    a_r8_storage: assert (bp_hit_o || !(|wp_hit_o) || (kind == EXC_STORAGE))
      else $error("R8 watchpoint hit not reported as storage");
    a_r8_idle: assert ((kind != EXC_NONE) || (excp_status_o == '0))
      else $error("R8 status nonzero with no event");
    a_r1_problem: assert (!bp_hit_o || ({bp_ctl_i[1], bp_ctl_i[0]} != 2'd1) || state_pr_i)
      else $error("R1 problem-class breakpoint outside problem state");
    a_r3_hyper: assert (!bp_hit_o || ({bp_ctl_i[1], bp_ctl_i[0]} != 2'd3) ||
                        (!state_pr_i && state_hv_i))
      else $error("R3 hypervisor-class breakpoint outside hypervisor state");
  end

endmodule

// File: tb/dbg_qual_test.sv
`timescale 1ns/1ps
module dbg_qual_test;

  localparam int CW = 64;
  localparam int NW = 2;
  localparam int NV = 10;
  localparam logic [63:0] ST_STG = 64'h0000_0000_0040_0000;
  localparam logic [63:0] ST_TRC = 64'h0000_0000_4010_0000;

  typedef struct packed {
    logic       pr, hv, dr;
    logic [1:0] bpv;
    logic       bpm;
    logic [4:0] w0;   // {sel, ign, hven, sven, pren}
    logic       w0m;
    logic [4:0] w1;
    logic       w1m;
    logic       ebp;
    logic [1:0] ewp;
    logic [1:0] ekind;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1,0,0, 2'd1,1, 5'b01011,1, 5'b00000,0, 1, 2'b01, 2'd2},
    '{0,0,0, 2'd2,1, 5'b01010,1, 5'b00010,1, 1, 2'b11, 2'd2},
    '{0,1,0, 2'd3,1, 5'b01010,1, 5'b01110,1, 1, 2'b10, 2'd2},
    '{0,1,0, 2'd2,1, 5'b00000,1, 5'b00000,0, 0, 2'b00, 2'd0},
    '{1,0,1, 2'd0,1, 5'b10011,1, 5'b00011,1, 0, 2'b01, 2'd1},
    '{0,0,1, 2'd1,1, 5'b00010,1, 5'b01010,1, 0, 2'b10, 2'd1},
    '{1,1,0, 2'd3,1, 5'b01111,1, 5'b01011,1, 0, 2'b01, 2'd1},
    '{0,0,0, 2'd2,0, 5'b01010,0, 5'b11111,0, 0, 2'b00, 2'd0},
    '{1,0,0, 2'd1,0, 5'b01010,1, 5'b01011,1, 0, 2'b10, 2'd1},
    '{0,0,1, 2'd3,1, 5'b10010,1, 5'b10010,1, 0, 2'b11, 2'd1}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                   pr, hv, dr, bpm;
  logic [CW-1:0]          bp_ctl;
  logic [NW-1:0][CW-1:0]  wp_ctl;
  logic [NW-1:0]          wpm;
  logic                   bp_hit;
  logic [NW-1:0]          wp_hit;
  logic [1:0]             kind;
  logic [63:0]            status;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  dbg_qual uut (
    .state_pr_i    (pr),
    .state_hv_i    (hv),
    .state_dr_i    (dr),
    .bp_ctl_i      (bp_ctl),
    .bp_match_i    (bpm),
    .wp_ctl_i      (wp_ctl),
    .wp_match_i    (wpm),
    .bp_hit_o      (bp_hit),
    .wp_hit_o      (wp_hit),
    .excp_kind_o   (kind),
    .excp_status_o (status)
  );

  function automatic logic m_bp(logic p, logic h, logic [1:0] v, logic m);
    return m && ((v == 2'd1 && p) || (v == 2'd2 && !p && !h) || (v == 2'd3 && !p && h));
  endfunction

  function automatic logic m_wp(logic p, logic h, logic d, logic [4:0] w, logic m);
    logic ok;
    ok = w[1];
    if (p && !w[0]) ok = 1'b0;
    if (h && !w[2]) ok = 1'b0;
    if (!w[3] && (d != w[4])) ok = 1'b0;
    return m && ok;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic apply(logic p, logic h, logic d, logic [1:0] v, logic m,
                       logic [4:0] w0, logic m0, logic [4:0] w1, logic m1);
    @(posedge clk);
    #1;
    pr = p; hv = h; dr = d; bpm = m;
    bp_ctl    = {62'b0, v};
    wp_ctl[0] = {59'b0, w0};
    wp_ctl[1] = {59'b0, w1};
    wpm = {m1, m0};
    @(negedge clk);
  endtask

  task automatic chk_kind(string req, logic eb, logic [1:0] ew);
    logic [1:0]  ek;
    logic [63:0] es;
    if (eb)      begin ek = 2'd2; es = ST_TRC; end
    else if (|ew) begin ek = 2'd1; es = ST_STG; end
    else         begin ek = 2'd0; es = '0;     end
    chk(req, {62'b0, kind}, {62'b0, ek});
    chk(req, status, es);
  endtask

  initial begin
    pr = 0; hv = 0; dr = 0; bpm = 0; bp_ctl = '0; wp_ctl = '0; wpm = '0;
    @(negedge clk);
    // idle: nothing matched
    chk("R4 idle bp", {63'b0, bp_hit}, 64'd0);
    chk("R4 idle wp", {62'b0, wp_hit}, 64'd0);
    chk("R8 idle kind", {62'b0, kind}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].pr, VECS[i].hv, VECS[i].dr, VECS[i].bpv, VECS[i].bpm,
            VECS[i].w0, VECS[i].w0m, VECS[i].w1, VECS[i].w1m);
      chk("R1 R2 R3 R4 table bp", {63'b0, bp_hit}, {63'b0, VECS[i].ebp});
      chk("R5 R6 R7 table wp", {62'b0, wp_hit}, {62'b0, VECS[i].ewp});
      chk("R8 table kind", {62'b0, kind}, {62'b0, VECS[i].ekind});
    end

    // breakpoint sweep: every state, class and match
    for (int s = 0; s < 32; s++) begin
      logic [4:0] b;
      logic e;
      b = s[4:0];
      apply(b[4], b[3], 1'b0, b[2:1], b[0], 5'b0, 1'b0, 5'b0, 1'b0);
      e = m_bp(b[4], b[3], b[2:1], b[0]);
      chk("R1 R2 R3 R4 sweep bp", {63'b0, bp_hit}, {63'b0, e});
      chk_kind("R8 sweep bp kind", e, 2'b00);
    end

    // watchpoint sweep per lane, other lane armed but unmatched
    for (int l = 0; l < NW; l++) begin
      for (int s = 0; s < 256; s++) begin
        logic [7:0] b;
        logic e;
        logic [1:0] ew;
        b = s[7:0];
        if (l == 0)
          apply(b[7], b[6], b[5], 2'd0, 1'b0, b[4:0], 1'b1, 5'b11111, 1'b0);
        else
          apply(b[7], b[6], b[5], 2'd0, 1'b0, 5'b11111, 1'b0, b[4:0], 1'b1);
        e  = m_wp(b[7], b[6], b[5], b[4:0], 1'b1);
        ew = (l == 0) ? {1'b0, e} : {e, 1'b0};
        chk("R5 R6 sweep wp", {63'b0, wp_hit[l]}, {63'b0, e});
        chk("R7 other lane quiet", {62'b0, wp_hit}, {62'b0, ew});
        chk_kind("R8 sweep wp kind", 1'b0, ew);
      end
    end

    // R4: fully enabled watchpoints and breakpoint, no raw match
    apply(1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 5'b11111, 1'b0, 5'b01111, 1'b0);
    chk("R4 nomatch bp", {63'b0, bp_hit}, 64'd0);
    chk("R4 nomatch wp", {62'b0, wp_hit}, 64'd0);

    // R8: both kinds at once resolves to trace
    apply(1'b0, 1'b1, 1'b0, 2'd3, 1'b1, 5'b01110, 1'b1, 5'b01110, 1'b1);
    chk_kind("R8 both fire", 1'b1, 2'b11);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule